// File: doc/BRIEF.md
# Banked Register File Address Unit

This block sits between an 8-bit core's instruction decode and its data RAM. Each cycle it takes a 7-bit file address from the instruction, together with read and write strobes and write data. It turns that address into a 9-bit physical RAM address.

- **Direct accesses** are placed in one of four 128-byte banks. Two bank-select bits in the status register choose the bank.
- **Indirect accesses** use an 8-bit pointer register extended by a ninth status bit. Address 00h is a virtual slot that triggers them.

The block owns the status and pointer registers. These answer at fixed low addresses in every bank and never reach the RAM.

ALU flag results enter on a separate port with a per-flag mask. The status write rules are enforced here:
- **Flag bits:** a data write to status cannot override flag bits when the same instruction also produces flags.
- **Power-status bits:** these cannot be written at all.

The RAM is an external synchronous array. Its address, strobes and write data come straight from the current request. Read results from RAM or from the core registers appear on `rd_data_o` one cycle after the request.

Status layout (bit 7 down to 0): indirect bank bit, bank select high, bank select low, time-out, power-down, Z, DC, C.

Top module: `rfa_bank_addr_unit`

## Requirements
- R1: A direct access (address not 00h) drives `ram_addr_o` = {status[6:5], address} in the same cycle; 00 selects bank 0 and 01 bank 1.
- R2: An access to address 00h drives `ram_addr_o` = {status[7], pointer}.
- R3: A resolved address whose low 7 bits are 03h (status) or 04h (pointer) hits the core register in every bank and through the pointer; it raises neither RAM strobe; a read returns the register, a write to 04h loads the pointer.
- R4: An indirect access whose pointer low 7 bits are 00h reads 00h and raises no RAM read.
- R5: Such a self-referencing indirect write changes no RAM and no register, while flag updates of the same cycle still apply.
- R6: A status write in a cycle where any flag mask bit is set ignores data bits 2:0; masked flags take the ALU values and unmasked flags keep their value.
- R7: A status write with an all-zero flag mask loads bits 7:5 and 2:0 from the data.
- R8: The time-out (bit 4) and power-down (bit 3) bits never change through a data write.
- R9: Reset sets status to 18h (bits 7:5 clear, time-out and power-down set, flags clear), the pointer to 00h and `rd_data_o` to 00h.
- R10: Writing 00h to status with only the Z mask set and Z value 1 yields status 000u u1uu.
- R11: `rd_data_o` presents the read result in the cycle after the request, taking RAM data from `ram_rdata_i`, and is 00h after a cycle without a read.
- R12: Flag mask bits (2 = Z, 1 = DC, 0 = C) update the matching status bits every cycle, with or without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr_i | input | 7 | File address from the instruction |
| acc_rd_i | input | 1 | Read request |
| acc_wr_i | input | 1 | Write request |
| acc_wdata_i | input | 8 | Write data |
| flg_mask_i | input | 3 | Flags produced this cycle (Z, DC, C) |
| flg_val_i | input | 3 | ALU flag values (Z, DC, C) |
| rd_data_o | output | 8 | Read result, one cycle after the request |
| ram_addr_o | output | 9 | Physical RAM address |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after `ram_re_o` |

## Verification
A wrong bank or indirect bit in status shows in the same cycle as a misplaced `ram_addr_o`. A broken pointer shows the same way. The reference model compares the RAM strobes and address every cycle, so such a fault is reported on the very next access. A wrong flag, time-out or power-down value stays hidden until status is read back, which the sequence does after each status write rule. A missed self-reference guard shows at once as a stray RAM strobe or as a non-zero read one cycle later.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int STAT_W = 8;
  localparam int FLG_W  = 3;
  localparam int ST_PD  = 3;
  localparam int ST_TO  = 4;
  localparam int ST_RP0 = 5;
  localparam int ST_IRP = 7;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_STAT,
    SRC_PTR,
    SRC_RAM
  } rd_src_e;
endpackage

// File: rtl/rfa_addr_map.sv
module rfa_addr_map #(
  parameter int ADDR_W    = 7,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 8,
  parameter int IND_ADDR  = 0,
  parameter int STAT_ADDR = 3,
  parameter int PTR_ADDR  = 4,
  localparam int PA_W     = ADDR_W + BANK_W
) (
  input  logic [ADDR_W-1:0] file_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ind_bank,
  input  logic [DATA_W-1:0] ptr,
  output logic [PA_W-1:0]   phys,
  output logic              hit_ind,
  output logic              hit_stat,
  output logic              hit_ptr
);
  logic             use_ptr;
  logic [ADDR_W-1:0] low;

  always_comb begin
    use_ptr = (file_addr == ADDR_W'(IND_ADDR));
    if (use_ptr) phys = PA_W'({ind_bank, ptr});
    else         phys = {bank_sel, file_addr};
    low      = phys[ADDR_W-1:0];
    hit_ind  = (low == ADDR_W'(IND_ADDR));
    hit_stat = (low == ADDR_W'(STAT_ADDR));
    hit_ptr  = (low == ADDR_W'(PTR_ADDR));
  end
endmodule

// File: rtl/rfa_status.sv
module rfa_status
  import rfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [FLG_W-1:0]  flg_mask,
  input  logic [FLG_W-1:0]  flg_val,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [STAT_W-1:0] RST_VAL = STAT_W'((1 << ST_TO) | (1 << ST_PD));

  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en) begin
      stat_d[STAT_W-1:ST_RP0] = wr_data[STAT_W-1:ST_RP0];
      if (flg_mask == '0) stat_d[FLG_W-1:0] = wr_data[FLG_W-1:0];
    end
    for (int i = 0; i < FLG_W; i++)
      if (flg_mask[i]) stat_d[i] = flg_val[i];
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= RST_VAL;
    else     stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_PWR_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(stat_q[ST_TO:ST_PD])); // R8

  AST_UPPER_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> stat_q[STAT_W-1:ST_RP0] == $past(wr_data[STAT_W-1:ST_RP0])); // R7

  for (genvar g = 0; g < FLG_W; g++) begin : g_flag_chk
    AST_FLAG_FROM_ALU: assert property (@(posedge clk) disable iff (rst)
      flg_mask[g] |=> stat_q[g] == $past(flg_val[g])); // R12
    AST_FLAG_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (flg_mask != '0) && !flg_mask[g]) |=> $stable(stat_q[g])); // R6
  end
endmodule

// File: rtl/rfa_bank_addr_unit.sv
module rfa_bank_addr_unit
  import rfa_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 8,
  parameter int IND_ADDR  = 0,
  parameter int STAT_ADDR = 3,
  parameter int PTR_ADDR  = 4,
  localparam int PA_W     = ADDR_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [FLG_W-1:0]  flg_mask_i,
  input  logic [FLG_W-1:0]  flg_val_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PA_W-1:0]   ram_addr_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic [STAT_W-1:0] stat;
  logic [DATA_W-1:0] ptr_q;
  logic              hit_ind, hit_stat, hit_ptr, hit_core;
  rd_src_e           src_d, src_q;
  logic [DATA_W-1:0] val_d, val_q;

  rfa_addr_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .IND_ADDR(IND_ADDR), .STAT_ADDR(STAT_ADDR), .PTR_ADDR(PTR_ADDR)
  ) u_map (
    .file_addr (acc_addr_i),
    .bank_sel  (stat[ST_RP0 +: BANK_W]),
    .ind_bank  (stat[ST_IRP]),
    .ptr       (ptr_q),
    .phys      (ram_addr_o),
    .hit_ind   (hit_ind),
    .hit_stat  (hit_stat),
    .hit_ptr   (hit_ptr)
  );

  rfa_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (acc_wr_i && hit_stat),
    .wr_data  (STAT_W'(acc_wdata_i)),
    .flg_mask (flg_mask_i),
    .flg_val  (flg_val_i),
    .stat_o   (stat)
  );

  assign hit_core    = hit_ind || hit_stat || hit_ptr;
  assign ram_re_o    = acc_rd_i && !hit_core;
  assign ram_we_o    = acc_wr_i && !hit_core;
  assign ram_wdata_o = acc_wdata_i;

  always_ff @(posedge clk) begin
    if (rst)                       ptr_q <= '0;
    else if (acc_wr_i && hit_ptr)  ptr_q <= acc_wdata_i;
  end

  always_comb begin
    src_d = SRC_NONE;
    val_d = '0;
    if (acc_rd_i) begin
      if (hit_stat)      begin src_d = SRC_STAT; val_d = DATA_W'(stat); end
      else if (hit_ptr)  begin src_d = SRC_PTR;  val_d = ptr_q; end
      else if (!hit_ind) src_d = SRC_RAM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_NONE;
      val_q <= '0;
    end else begin
      src_q <= src_d;
      val_q <= val_d;
    end
  end

  assign rd_data_o = (src_q == SRC_RAM) ? ram_rdata_i : val_q;

  AST_SELF_IND_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_rd_i && hit_ind) |=> rd_data_o == '0); // R4

  AST_CORE_NO_RAM: assert property (@(posedge clk) disable iff (rst)
    hit_core |-> !ram_we_o && !ram_re_o); // R5

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (acc_wr_i && hit_ptr) |=> ptr_q == $past(acc_wdata_i)); // R3
endmodule

// File: tb/rfa_bank_addr_unit_tb.sv
`timescale 1ns/1ps
module rfa_bank_addr_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] acc_addr;
  logic       acc_rd, acc_wr;
  logic [7:0] acc_wdata;
  logic [2:0] flg_mask, flg_val;
  logic [7:0] rd_data;
  logic [8:0] ram_addr;
  logic       ram_re, ram_we;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] hmem [512];
  logic [7:0] mmem [512];
  logic [7:0] m_st, m_ptr;

  always #2 clk = ~clk;

  rfa_bank_addr_unit u_dut (
    .clk(clk), .rst(rst),
    .acc_addr_i(acc_addr), .acc_rd_i(acc_rd), .acc_wr_i(acc_wr),
    .acc_wdata_i(acc_wdata), .flg_mask_i(flg_mask), .flg_val_i(flg_val),
    .rd_data_o(rd_data), .ram_addr_o(ram_addr), .ram_re_o(ram_re),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) hmem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= hmem[ram_addr];
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] a, input logic rd, input logic wr,
                      input logic [7:0] d, input logic [2:0] m,
                      input logic [2:0] v, input string tag);
    logic [8:0] ph;
    logic [6:0] lo;
    logic       core;
    logic [7:0] erd, nst;
    acc_addr = a; acc_rd = rd; acc_wr = wr; acc_wdata = d;
    flg_mask = m; flg_val = v;
    #1;
    ph   = (a == 7'h00) ? {m_st[7], m_ptr} : {m_st[6:5], a};
    lo   = ph[6:0];
    core = (lo == 7'h00) || (lo == 7'h03) || (lo == 7'h04);
    chk(ram_re == (rd && !core), tag, "ram_re", int'(ram_re), int'(rd && !core));
    chk(ram_we == (wr && !core), tag, "ram_we", int'(ram_we), int'(wr && !core));
    if ((rd || wr) && !core) chk(ram_addr == ph, tag, "ram_addr", ram_addr, ph);
    if (wr && !core) chk(ram_wdata == d, tag, "ram_wdata", ram_wdata, d);
    if (!rd)               erd = 8'h00;
    else if (lo == 7'h00)  erd = 8'h00;
    else if (lo == 7'h03)  erd = m_st;
    else if (lo == 7'h04)  erd = m_ptr;
    else                   erd = mmem[ph];
    nst = m_st;
    if (wr && lo == 7'h03) begin
      nst[7:5] = d[7:5];
      if (m == 3'b000) nst[2:0] = d[2:0];
    end
    for (int i = 0; i < 3; i++) if (m[i]) nst[i] = v[i];
    if (wr && !core) mmem[ph] = d;
    if (wr && lo == 7'h04) m_ptr = d;
    m_st = nst;
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == erd, tag, "rd_data", rd_data, erd);
  endtask

  task automatic rd_stat(input logic [7:0] exp, input string tag);
    step(7'h03, 1'b1, 1'b0, 8'h00, 3'b000, 3'b000, tag);
    chk(m_st == exp, tag, "model status", m_st, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      hmem[i] = 8'(i * 7 + 3);
      mmem[i] = 8'(i * 7 + 3);
    end
    ram_rdata = 8'h00;
    rst = 1'b1; acc_addr = '0; acc_rd = 0; acc_wr = 0; acc_wdata = '0;
    flg_mask = '0; flg_val = '0;
    m_st = 8'h18; m_ptr = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(rd_data == 8'h00, "R9", "rd_data after reset", rd_data, 0);
    rd_stat(8'h18, "R9");
    step(7'h04, 1, 0, 8'h00, 3'b000, 3'b000, "R9");
    // R11: no read gives zero
    step(7'h20, 0, 0, 8'h00, 3'b000, 3'b000, "R11");
    // R1: bank 0 direct write then read
    step(7'h20, 0, 1, 8'hA5, 3'b000, 3'b000, "R1");
    step(7'h20, 1, 0, 8'h00, 3'b000, 3'b000, "R1");
    step(7'h7F, 1, 0, 8'h00, 3'b000, 3'b000, "R11");
    // R7: select bank 1
    step(7'h03, 0, 1, 8'h20, 3'b000, 3'b000, "R7");
    rd_stat(8'h38, "R7");
    step(7'h30, 0, 1, 8'h5C, 3'b000, 3'b000, "R1");
    step(7'h30, 1, 0, 8'h00, 3'b000, 3'b000, "R1");
    // R8: cannot clear power bits
    step(7'h03, 0, 1, 8'h07, 3'b000, 3'b000, "R8");
    rd_stat(8'h1F, "R8");
    // R6: write with C produced
    step(7'h03, 0, 1, 8'hE0, 3'b001, 3'b000, "R6");
    rd_stat(8'hFE, "R6");
    // R3: status mirrored in bank 3
    step(7'h03, 1, 0, 8'h00, 3'b000, 3'b000, "R3");
    // R10: clear status
    step(7'h03, 0, 1, 8'h00, 3'b100, 3'b100, "R10");
    rd_stat(8'h1E, "R10");
    // R2: indirect with bank bit clear then set
    step(7'h04, 0, 1, 8'h45, 3'b000, 3'b000, "R3");
    step(7'h00, 0, 1, 8'h99, 3'b000, 3'b000, "R2");
    step(7'h00, 1, 0, 8'h00, 3'b000, 3'b000, "R2");
    step(7'h03, 0, 1, 8'h80, 3'b000, 3'b000, "R7");
    step(7'h00, 1, 0, 8'h00, 3'b000, 3'b000, "R2");
    step(7'h00, 0, 1, 8'h3C, 3'b000, 3'b000, "R2");
    step(7'h45, 1, 0, 8'h00, 3'b000, 3'b000, "R2");
    // R4 / R5: self-referencing pointer
    step(7'h04, 0, 1, 8'h80, 3'b000, 3'b000, "R4");
    step(7'h00, 1, 0, 8'h00, 3'b000, 3'b000, "R4");
    step(7'h00, 0, 1, 8'h55, 3'b100, 3'b100, "R5");
    step(7'h04, 1, 0, 8'h00, 3'b000, 3'b000, "R5");
    rd_stat(8'h9C, "R5");
    // R3: pointer aims at status
    step(7'h04, 0, 1, 8'h83, 3'b000, 3'b000, "R3");
    step(7'h00, 1, 0, 8'h00, 3'b000, 3'b000, "R3");
    step(7'h00, 0, 1, 8'h01, 3'b000, 3'b000, "R3");
    rd_stat(8'h19, "R3");
    // R12: flags without access
    step(7'h10, 0, 0, 8'h00, 3'b011, 3'b010, "R12");
    rd_stat(8'h1A, "R12");
    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [2:0] mm;
      mm = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      step(7'($urandom_range(0, 15) < 4 ? $urandom_range(0, 5) : $urandom),
           1'($urandom), 1'($urandom), 8'($urandom), mm, 3'($urandom), "R6");
    end
    rd_stat(m_st, "R8");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule